// File: doc/BRIEF.md
# Two-Lamp Alternating Sequencer

This block alternates two lamp outputs while it is running. Each lamp stays on for a fixed number of time-base strobes. A run/halt latch with a start input and a stop input gates the whole sequence, and stop wins over start. Each of the two phases is timed by a retentive interval counter. The second counter advances only once the first has reached its preset. When the second counter reaches its preset, both counters are cleared and the cycle begins again with the first lamp.

Halting the latch turns both lamps off but leaves both counters as they are. A later start therefore continues the sequence from the same point, possibly partway through a phase. The phase length is the parameter `PRESET_TICKS`. The time base is an external single-cycle strobe, `tick`, so one phase lasts `PRESET_TICKS` strobes.

Two state machines, named here, describe the block:

- **Run latch.** It has two states, `ST_HALTED` and `ST_RUNNING`.
  - `ST_HALTED` goes to `ST_RUNNING` on start without stop.
  - `ST_RUNNING` goes to `ST_HALTED` on stop.
  - Every other case keeps the current state.
- **Phase.** It is decoded from the two counters.
  - `PH_LAMP_A` holds while counter one is below its preset.
  - `PH_LAMP_B` holds while counter one is done and counter two is below its preset.
  - `PH_WRAP` holds for the single cycle in which counter two is done.
  - The phase moves `PH_LAMP_A` to `PH_LAMP_B` to `PH_WRAP`, then back to `PH_LAMP_A`.

Top module: `lamp_sequencer`

## Requirements
- R1: `master` = (`start` OR held) AND NOT `stop`, where held is the value `master` had in the previous clock cycle. `master` responds combinationally to `start` and `stop` in the same cycle.
- R2: While `stop` is 1, `master`, `light1` and `light2` are all 0, even when `start` is 1.
- R3: `light1` = `master` AND (counter one < `PRESET_TICKS`).
- R4: Counter one adds 1 at a clock edge where `master` and `tick` are both 1. Counter two adds 1 at an edge where `master`, `tick` and counter-one-done are all 1. Neither counter ever exceeds `PRESET_TICKS`, and without `tick` neither counter changes.
- R5: `light2` = `master` AND counter-one-done AND NOT counter-two-done. `light1` and `light2` are never both 1.
- R6: In the cycle where counter two equals `PRESET_TICKS`, both lamps are 0. At the next edge both counters become 0, so the sequence restarts with `light1`.
- R7: While `master` is 0, neither counter changes, except for the clear of R6. A later start resumes with the remaining strobes of the interrupted phase.
- R8: `rst_n` = 0 clears the latch and both counters. After reset, the first start lights `light1`.
- R9: With `master` held at 1 and `tick` at 1 in every cycle, the outputs repeat with a period of 2·`PRESET_TICKS`+1 cycles:
  - `light1` is on for `PRESET_TICKS` cycles,
  - then `light2` is on for `PRESET_TICKS` cycles,
  - then there is one cycle with both lamps off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, level sampled every cycle |
| stop | input | 1 | Stop request, dominant over start |
| tick | input | 1 | Time-base strobe, one cycle wide |
| master | output | 1 | Run latch output |
| light1 | output | 1 | First lamp |
| light2 | output | 1 | Second lamp |

## Verification
The assertions take `start`, `stop` and `tick` to be synchronous levels that are stable around each rising edge. They also take `PRESET_TICKS` to be at least 1, so that a done counter is distinguishable from a cleared one. The bench changes every input only at the falling edge and uses a preset of 3, so that many full cycles, wraps and interruptions fit into a short run. Its pseudo-random stimulus makes stop rarer than start. This keeps long running stretches reachable while still interrupting each phase at arbitrary strobe counts.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        PH_LAMP_A = 2'd0,
        PH_LAMP_B = 2'd1,
        PH_WRAP   = 2'd2
    } phase_e;
endpackage

// File: rtl/seal_latch.sv
module seal_latch
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic run_now
);
    run_state_e state_q, state_d;

    // next-state: stop dominates, start seals in
    always_comb begin
        unique case (state_q)
            ST_HALTED:  state_d = (start && !stop) ? ST_RUNNING : ST_HALTED;
            ST_RUNNING: state_d = stop ? ST_HALTED : ST_RUNNING;
            default:    state_d = ST_HALTED;
        endcase
    end

    assign run_now = (state_d == ST_RUNNING);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/retentive_timer.sv
module retentive_timer #(
    parameter int unsigned PRESET = 50,
    parameter int unsigned CW     = $clog2(PRESET + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          clear,
    input  logic          tick,
    output logic [CW-1:0] acc,
    output logic          done
);
    localparam logic [CW-1:0] LIMIT = CW'(PRESET);

    assign done = (acc >= LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        acc <= '0;
        else if (clear)                    acc <= '0;
        else if (enable && tick && !done)  acc <= acc + 1'b1;
    end
endmodule

// File: rtl/lamp_sequencer.sv
module lamp_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned PRESET_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic tick,
    output logic master,
    output logic light1,
    output logic light2
);
    localparam int unsigned CW = $clog2(PRESET_TICKS + 1);

    logic          t1_done, t2_done;
    logic [CW-1:0] t1_acc, t2_acc;
    phase_e        phase;

    seal_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .stop    (stop),
        .run_now (master)
    );

    retentive_timer #(.PRESET(PRESET_TICKS), .CW(CW)) u_tmr_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (master),
        .clear  (t2_done),
        .tick   (tick),
        .acc    (t1_acc),
        .done   (t1_done)
    );

    retentive_timer #(.PRESET(PRESET_TICKS), .CW(CW)) u_tmr_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (master && t1_done),
        .clear  (t2_done),
        .tick   (tick),
        .acc    (t2_acc),
        .done   (t2_done)
    );

    // phase decode from the two done flags
    always_comb begin
        if (t2_done)      phase = PH_WRAP;
        else if (t1_done) phase = PH_LAMP_B;
        else              phase = PH_LAMP_A;
    end

    // lamp outputs per phase, gated by the run latch
    always_comb begin
        light1 = 1'b0;
        light2 = 1'b0;
        unique case (phase)
            PH_LAMP_A: light1 = master;
            PH_LAMP_B: light2 = master;
            PH_WRAP:   ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int unsigned PRESET = 50,
    parameter int unsigned CW     = $clog2(PRESET + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop,
    input logic          master,
    input logic          light1,
    input logic          light2,
    input logic [CW-1:0] acc1,
    input logic [CW-1:0] acc2,
    input logic          done2
);
    p_stop_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> (!master && !light1 && !light2));

    p_seal_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        master |=> (stop || master));

    p_lamp_needs_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (light1 || light2) |-> master);

    p_lamps_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(light1 && light2));

    p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc1 <= CW'(PRESET)) && (acc2 <= CW'(PRESET)));

    p_wrap_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done2 |=> (acc1 == '0 && acc2 == '0));

    p_retain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && !done2) |=> ($stable(acc1) && $stable(acc2)));
endmodule

bind lamp_sequencer seq_checker #(.PRESET(PRESET_TICKS), .CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .stop   (stop),
    .master (master),
    .light1 (light1),
    .light2 (light2),
    .acc1   (t1_acc),
    .acc2   (t2_acc),
    .done2  (t2_done)
);

// File: tb/sim_lamp_sequencer.sv
module sim_lamp_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, tick = 1'b0;
    logic master, light1, light2;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference state
    bit m_run = 1'b0;
    int m_a1  = 0;
    int m_a2  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lamp_sequencer #(.PRESET_TICKS(P)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick(tick),
        .master(master), .light1(light1), .light2(light2)
    );

    task automatic cmp(input logic got, input logic exp, input string req, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] got %b expected %b at %0t", req, tag, got, exp, $time);
        end
    endtask

    task automatic step(input logic s, input logic p, input logic t, input string tag);
        bit em, el1, el2, d1, d2;
        @(negedge clk);
        start = s; stop = p; tick = t;
        #1;
        d1  = (m_a1 >= P);
        d2  = (m_a2 >= P);
        em  = (s || m_run) && !p;
        el1 = em && !d1;
        el2 = em && d1 && !d2;
        cmp(master, em,  p ? "R2 master" : "R1 master", tag);
        cmp(light1, el1, p ? "R2 light1" : "R3 light1", tag);
        cmp(light2, el2, p ? "R2 light2" : "R5 light2", tag);
        m_run = em;
        if (d2) begin
            m_a1 = 0;
            m_a2 = 0;
        end else begin
            if (em && t && !d1) m_a1++;
            if (em && t && d1 && !d2) m_a2++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; stop = 1'b0; tick = 1'b0;
        m_run = 1'b0; m_a1 = 0; m_a2 = 0;
        @(negedge clk);
        #1;
        cmp(master, 1'b0, "R8 master", "in reset");
        cmp(light1, 1'b0, "R8 light1", "in reset");
        cmp(light2, 1'b0, "R8 light2", "in reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [15:0] lfsr;
        do_reset();
        step(0, 0, 1, "R8 idle after reset");
        // full cycles with tick every cycle
        step(1, 0, 1, "R1 start");
        for (int i = 0; i < 2*(2*P+1) + 2; i++) step(0, 0, 1, "R9 R6 wrap sequence");
        // move into lamp B partway
        for (int i = 0; i < P + 1; i++) step(0, 0, 1, "R9 into phase B");
        step(1, 1, 1, "R2 start with stop");
        for (int i = 0; i < 4; i++) step(0, 0, 1, "R7 halted, ticks ignored");
        step(1, 0, 0, "R7 resume");
        for (int i = 0; i < 2*P + 2; i++) step(0, 0, 1, "R7 remaining phase");
        for (int i = 0; i < 5; i++) step(0, 0, 0, "R4 no tick");
        step(0, 0, 1, "R4 single tick");
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R4 no tick after");
        // reset mid-run, then restart from lamp A
        do_reset();
        step(1, 0, 1, "R8 first start lights lamp A");
        for (int i = 0; i < P; i++) step(0, 0, 1, "R8 R3 run");
        // pseudo-random sweep
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:5] == 3'd0, lfsr[3:0] == 4'd0, lfsr[9] | lfsr[10], "R1 R7 sweep");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog [timeout] got running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule